// File: doc/BRIEF.md
# Custom Opcode Dispatch and Stall Controller

This block sits between the decode stage of a CPU and an attached functional unit that executes user-defined instructions. Every decoded instruction word is checked for the reserved custom opcode. The block splits the word into its destination, source and immediate fields, and drives the two register-file read addresses from the word as it arrives. When the custom extension is enabled, a matching instruction is issued to the unit together with both operand values and both immediate fields. When the extension is disabled, the instruction is flagged as illegal. Only the opcode is validated. The immediate fields are passed to the unit unchecked, so any value is accepted.

Once an instruction is issued, the pipeline is stalled until the unit reports completion. There is no time limit on this wait. The result is then written back to the destination register, except when that register is x0. Interrupt requests that arrive during the stall are captured and held. They are not presented to the trap logic until the stall has ended, and none is lost.

Top module: `xop_dispatch_ctrl`

## Requirements
- R1: After reset, stall, illegal, xu_start, wb_we and irq_pend are all 0.
- R2: An instruction is custom when bits [6:0] equal 7'b0001011. The fields are rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20] and funct7 [31:25]. rf_raddr1 and rf_raddr2 follow bits [19:15] and [24:20] of dec_instr in the same cycle.
- R3: A valid custom instruction accepted while idle with ext_en=1 gives, in the next cycle, xu_start=1 for exactly one cycle and stall=1. xu_funct3, xu_funct7, xu_op1 and xu_op2 carry the instruction's fields and the sampled rf_rdata1 and rf_rdata2.
- R4: With ext_en=1, every value of funct3 and funct7 is accepted, and illegal stays 0.
- R5: A valid custom instruction with ext_en=0 gives illegal=1 for exactly one cycle, in the next cycle. It starts nothing and does not stall.
- R6: An instruction whose opcode is not custom causes no start, no illegal flag and no stall.
- R7: stall stays 1, and xu_op1, xu_op2, xu_funct3 and xu_funct7 stay stable, for as long as xu_done is 0, with no upper bound.
- R8: In the cycle after xu_done is sampled high, wb_we=1 for one cycle, with wb_addr equal to rd and wb_data equal to xu_result. When rd is 0, wb_we stays 0.
- R9: stall falls in the cycle after the writeback cycle. An instruction with unit latency L, where done first appears L cycles after start, holds stall for L+2 cycles.
- R10: dec_valid has no effect while stall is 1. It causes no further start and no illegal flag.
- R11: A pulse on irq_req[k] sets a pending bit that stays set until irq_ack[k] is given outside a stall. That bit appears on irq_pend one cycle after the pulse, provided no stall is active.
- R12: While stall is 1, irq_pend reads 0 and irq_ack has no effect. Bits captured during the stall appear on irq_pend once stall falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Custom extension enable |
| dec_valid | input | 1 | Decode stage presents an instruction |
| dec_instr | input | 32 | Instruction word from decode |
| rf_raddr1 | output | 5 | Register file read address, first source |
| rf_raddr2 | output | 5 | Register file read address, second source |
| rf_rdata1 | input | XLEN | First source operand value |
| rf_rdata2 | input | XLEN | Second source operand value |
| stall | output | 1 | Holds the CPU pipeline |
| illegal | output | 1 | Illegal-instruction exception request |
| xu_start | output | 1 | One-cycle start pulse to the functional unit |
| xu_funct3 | output | 3 | Immediate field funct3 for the unit |
| xu_funct7 | output | 7 | Immediate field funct7 for the unit |
| xu_op1 | output | XLEN | First operand for the unit |
| xu_op2 | output | XLEN | Second operand for the unit |
| xu_done | input | 1 | Unit has finished; xu_result is valid |
| xu_result | input | XLEN | Unit result |
| wb_we | output | 1 | Register file write enable |
| wb_addr | output | 5 | Register file write address |
| wb_data | output | XLEN | Register file write data |
| irq_req | input | NIRQ | Incoming interrupt request pulses |
| irq_ack | input | NIRQ | Clears pending bits outside a stall |
| irq_pend | output | NIRQ | Pending requests shown to the trap logic |

## Verification
An accepted instruction shows xu_start and stall one cycle after the edge that sampled it. A rejected instruction shows illegal at the same delay. The read addresses are combinational and are checked shortly after the word is applied. Writeback appears one cycle after done is sampled, and stall falls one cycle after that, which gives L+2 stall cycles for latency L. The stimulus is driven on the falling edge and every output is compared on a later falling edge, so each check lands on the cycle in which the result is due. Expected writebacks are queued at issue time and compared as they appear. Interrupt bits are checked one cycle after a pulse, and both throughout and after a stall.

// File: rtl/xop_pkg.sv
`timescale 1ns/1ps
package xop_pkg;
    localparam logic [6:0] OPC_CUSTOM = 7'b0001011;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUSY = 2'd1,
        S_WB   = 2'd2
    } seq_state_e;

    // Field order of the 32-bit register-register instruction format
    typedef struct packed {
        logic [6:0] f7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] f3;
        logic [4:0] rd;
        logic [6:0] opc;
    } rword_t;
endpackage

// File: rtl/xop_decode.sv
`timescale 1ns/1ps
module xop_decode
    import xop_pkg::*;
#(
    parameter logic [6:0] MATCH_OPC = OPC_CUSTOM
) (
    input  logic [31:0] instr,
    output logic        is_custom,
    output logic [4:0]  rd,
    output logic [4:0]  rs1,
    output logic [4:0]  rs2,
    output logic [2:0]  f3,
    output logic [6:0]  f7
);
    rword_t w;

    always_comb begin
        w         = rword_t'(instr);
        // opcode is the only field inspected; funct3/funct7 pass unchecked
        is_custom = (w.opc == MATCH_OPC);
        rd        = w.rd;
        rs1       = w.rs1;
        rs2       = w.rs2;
        f3        = w.f3;
        f7        = w.f7;
    end
endmodule

// File: rtl/xop_seq.sv
`timescale 1ns/1ps
module xop_seq
    import xop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            reject,
    input  logic [4:0]      in_rd,
    input  logic [2:0]      in_f3,
    input  logic [6:0]      in_f7,
    input  logic [XLEN-1:0] in_op1,
    input  logic [XLEN-1:0] in_op2,
    input  logic            xu_done,
    input  logic [XLEN-1:0] xu_result,
    output logic            idle,
    output logic            xu_start,
    output logic [2:0]      xu_funct3,
    output logic [6:0]      xu_funct7,
    output logic [XLEN-1:0] xu_op1,
    output logic [XLEN-1:0] xu_op2,
    output logic            wb_we,
    output logic [4:0]      wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            illegal
);
    typedef struct packed {
        seq_state_e      state;
        logic            start;
        logic            illegal;
        logic [4:0]      rd;
        logic [2:0]      f3;
        logic [6:0]      f7;
        logic [XLEN-1:0] op1;
        logic [XLEN-1:0] op2;
        logic [XLEN-1:0] res;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.start   = 1'b0;
        r_d.illegal = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (issue) begin
                    r_d.state = S_BUSY;
                    r_d.start = 1'b1;
                    r_d.rd    = in_rd;
                    r_d.f3    = in_f3;
                    r_d.f7    = in_f7;
                    r_d.op1   = in_op1;
                    r_d.op2   = in_op2;
                end else if (reject) begin
                    r_d.illegal = 1'b1;
                end
            end
            S_BUSY: begin
                // no timeout: wait as long as the unit needs
                if (xu_done) begin
                    r_d.state = S_WB;
                    r_d.res   = xu_result;
                end
            end
            S_WB: begin
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idle      = (r_q.state == S_IDLE);
    assign xu_start  = r_q.start;
    assign xu_funct3 = r_q.f3;
    assign xu_funct7 = r_q.f7;
    assign xu_op1    = r_q.op1;
    assign xu_op2    = r_q.op2;
    assign wb_we     = (r_q.state == S_WB) && (r_q.rd != 5'd0);
    assign wb_addr   = r_q.rd;
    assign wb_data   = r_q.res;
    assign illegal   = r_q.illegal;

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xu_start |=> !xu_start);

    p_wait_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_BUSY && !xu_done) |=> (r_q.state == S_BUSY && $stable(xu_op1) && $stable(xu_op2)));

    p_wb_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_BUSY && xu_done && r_q.rd != 5'd0) |=> (wb_we && wb_data == $past(xu_result)));

    p_release_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_WB) |=> idle);

    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !illegal);
endmodule

// File: rtl/xop_irq_hold.sv
`timescale 1ns/1ps
module xop_irq_hold #(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_ack,
    output logic [NIRQ-1:0] irq_pend
);
    logic [NIRQ-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q | irq_req;
        if (!hold) begin
            pend_d = pend_d & ~irq_ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign irq_pend = hold ? '0 : pend_q;

    for (genvar k = 0; k < NIRQ; k++) begin : g_chk
        p_keep_in_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (hold && pend_q[k]) |=> pend_q[k]);
        p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[k] |=> pend_q[k]);
    end
endmodule

// File: rtl/xop_dispatch_ctrl.sv
`timescale 1ns/1ps
module xop_dispatch_ctrl
    import xop_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            dec_valid,
    input  logic [31:0]     dec_instr,
    output logic [4:0]      rf_raddr1,
    output logic [4:0]      rf_raddr2,
    input  logic [XLEN-1:0] rf_rdata1,
    input  logic [XLEN-1:0] rf_rdata2,
    output logic            stall,
    output logic            illegal,
    output logic            xu_start,
    output logic [2:0]      xu_funct3,
    output logic [6:0]      xu_funct7,
    output logic [XLEN-1:0] xu_op1,
    output logic [XLEN-1:0] xu_op2,
    input  logic            xu_done,
    input  logic [XLEN-1:0] xu_result,
    output logic            wb_we,
    output logic [4:0]      wb_addr,
    output logic [XLEN-1:0] wb_data,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_ack,
    output logic [NIRQ-1:0] irq_pend
);
    logic       is_custom;
    logic [4:0] f_rd, f_rs1, f_rs2;
    logic [2:0] f_f3;
    logic [6:0] f_f7;
    logic       idle, issue, reject;

    xop_decode #(.MATCH_OPC(OPC_CUSTOM)) u_dec (
        .instr     (dec_instr),
        .is_custom (is_custom),
        .rd        (f_rd),
        .rs1       (f_rs1),
        .rs2       (f_rs2),
        .f3        (f_f3),
        .f7        (f_f7)
    );

    assign rf_raddr1 = f_rs1;
    assign rf_raddr2 = f_rs2;
    assign issue     = dec_valid && is_custom && ext_en && idle;
    assign reject    = dec_valid && is_custom && !ext_en && idle;

    xop_seq #(.XLEN(XLEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .reject    (reject),
        .in_rd     (f_rd),
        .in_f3     (f_f3),
        .in_f7     (f_f7),
        .in_op1    (rf_rdata1),
        .in_op2    (rf_rdata2),
        .xu_done   (xu_done),
        .xu_result (xu_result),
        .idle      (idle),
        .xu_start  (xu_start),
        .xu_funct3 (xu_funct3),
        .xu_funct7 (xu_funct7),
        .xu_op1    (xu_op1),
        .xu_op2    (xu_op2),
        .wb_we     (wb_we),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .illegal   (illegal)
    );

    assign stall = !idle;

    xop_irq_hold #(.NIRQ(NIRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stall),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .irq_pend (irq_pend)
    );

    p_start_with_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xu_start |-> stall);

    p_illegal_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!xu_start && !stall));

    p_pend_hidden_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (irq_pend == '0));
endmodule

// File: tb/xop_dispatch_ctrl_tb.sv
`timescale 1ns/1ps
module xop_dispatch_ctrl_tb;
    localparam int XLEN = 32;
    localparam int NIRQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_en = 1'b1;
    logic dec_valid = 1'b0;
    logic [31:0] dec_instr = '0;
    logic [4:0] rf_raddr1, rf_raddr2;
    logic [XLEN-1:0] rf_rdata1 = '0, rf_rdata2 = '0;
    logic stall, illegal, xu_start;
    logic [2:0] xu_funct3;
    logic [6:0] xu_funct7;
    logic [XLEN-1:0] xu_op1, xu_op2;
    logic xu_done = 1'b0;
    logic [XLEN-1:0] xu_result = '0;
    logic wb_we;
    logic [4:0] wb_addr;
    logic [XLEN-1:0] wb_data;
    logic [NIRQ-1:0] irq_req = '0, irq_ack = '0, irq_pend;

    always #10 clk = ~clk;

    xop_dispatch_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .dec_valid(dec_valid),
        .dec_instr(dec_instr), .rf_raddr1(rf_raddr1), .rf_raddr2(rf_raddr2),
        .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2), .stall(stall),
        .illegal(illegal), .xu_start(xu_start), .xu_funct3(xu_funct3),
        .xu_funct7(xu_funct7), .xu_op1(xu_op1), .xu_op2(xu_op2),
        .xu_done(xu_done), .xu_result(xu_result), .wb_we(wb_we),
        .wb_addr(wb_addr), .wb_data(wb_data), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_pend(irq_pend)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                       input logic [4:0] r1, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {f7, r2, r1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] unit_fn(input logic [2:0] f3, input logic [6:0] f7,
                                            input logic [31:0] a, input logic [31:0] b);
        return (a ^ {b[15:0], b[31:16]}) + {22'd0, f7, f3};
    endfunction

    // functional unit model: done appears unit_lat cycles after start
    int unit_lat = 0;
    int remain = 0;
    bit model_busy = 1'b0;
    int start_cnt = 0;
    always @(negedge clk) begin
        if (xu_start) begin
            model_busy = 1'b1;
            remain = unit_lat;
            start_cnt++;
        end else if (xu_done) begin
            model_busy = 1'b0;
        end else if (model_busy && remain > 0) begin
            remain--;
        end
        xu_done = model_busy && (remain == 0);
        xu_result = unit_fn(xu_funct3, xu_funct7, xu_op1, xu_op2);
    end

    // scoreboard
    typedef struct packed { logic [4:0] addr; logic [31:0] data; } wb_item_t;
    wb_item_t exp_q[$];
    int wb_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && wb_we) begin
            wb_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected writeback", longint'(wb_addr), 0);
            end else begin
                wb_item_t e;
                e = exp_q.pop_front();
                check(wb_addr == e.addr, "R8 wb_addr", longint'(wb_addr), longint'(e.addr));
                check(wb_data == e.data, "R8 wb_data", longint'(wb_data), longint'(e.data));
            end
        end
    end

    // driver: called right after a falling edge
    task automatic issue(input logic [6:0] f7, input logic [4:0] r1, input logic [4:0] r2,
                         input logic [2:0] f3, input logic [4:0] rd,
                         input logic [31:0] a, input logic [31:0] b, input int lat);
        int cyc;
        unit_lat = lat;
        dec_instr = mk(f7, r2, r1, f3, rd, 7'b0001011);
        rf_rdata1 = a;
        rf_rdata2 = b;
        dec_valid = 1'b1;
        #1;
        check(rf_raddr1 == r1, "R2 rs1 field", longint'(rf_raddr1), longint'(r1));
        check(rf_raddr2 == r2, "R2 rs2 field", longint'(rf_raddr2), longint'(r2));
        if (rd != 5'd0) exp_q.push_back({rd, unit_fn(f3, f7, a, b)});
        @(negedge clk);
        dec_valid = 1'b0;
        check(xu_start == 1'b1, "R3 start", longint'(xu_start), 1);
        check(stall == 1'b1, "R3 stall", longint'(stall), 1);
        check(xu_funct3 == f3 && xu_funct7 == f7, "R3 immediates",
              longint'({xu_funct7, xu_funct3}), longint'({f7, f3}));
        check(xu_op1 == a && xu_op2 == b, "R3 operands", longint'(xu_op1), longint'(a));
        check(illegal == 1'b0, "R4 no illegal when enabled", longint'(illegal), 0);
        cyc = 1;
        forever begin
            @(negedge clk);
            if (!stall) break;
            cyc++;
            if (xu_start) check(1'b0, "R3 extra start", 1, 0);
            if (xu_op1 != a || xu_op2 != b || xu_funct3 != f3)
                check(1'b0, "R7 operands held", longint'(xu_op1), longint'(a));
        end
        check(cyc == lat + 2, "R9 stall length", longint'(cyc), longint'(lat + 2));
    endtask

    int wb_before;
    int st_before;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(stall == 0 && illegal == 0 && xu_start == 0 && wb_we == 0,
              "R1 reset outputs", longint'({stall, illegal, xu_start, wb_we}), 0);
        check(irq_pend == '0, "R1 reset irq_pend", longint'(irq_pend), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R8/R9: combinational unit (latency 0), then multi-cycle
        issue(7'h00, 5'd3, 5'd4, 3'b110, 5'd9, 32'h00CA_FE00, 32'h1234_5678, 0);
        issue(7'h27, 5'd31, 5'd1, 3'b001, 5'd17, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 3);
        // R4: extreme immediates are accepted
        issue(7'h7F, 5'd0, 5'd31, 3'b111, 5'd1, 32'hFFFF_FFFF, 32'h0000_0001, 1);
        // R7: long wait with no timeout
        issue(7'h55, 5'd7, 5'd8, 3'b010, 5'd30, 32'h8000_0000, 32'h7FFF_FFFF, 40);

        // R8: rd = x0 gives no write
        wb_before = wb_cnt;
        issue(7'h11, 5'd2, 5'd5, 3'b100, 5'd0, 32'h1111_1111, 32'h2222_2222, 2);
        repeat (2) @(negedge clk);
        check(wb_cnt == wb_before, "R8 rd=x0 no write", longint'(wb_cnt), longint'(wb_before));

        // R5: disabled extension
        ext_en = 1'b0;
        dec_instr = mk(7'h01, 5'd2, 5'd3, 3'b000, 5'd4, 7'b0001011);
        dec_valid = 1'b1;
        st_before = start_cnt;
        @(negedge clk);
        dec_valid = 1'b0;
        check(illegal == 1'b1, "R5 illegal raised", longint'(illegal), 1);
        check(stall == 1'b0 && xu_start == 1'b0, "R5 no start/stall",
              longint'({stall, xu_start}), 0);
        @(negedge clk);
        check(illegal == 1'b0, "R5 illegal one cycle", longint'(illegal), 0);
        ext_en = 1'b1;

        // R6: non-custom opcode
        dec_instr = mk(7'h00, 5'd2, 5'd3, 3'b000, 5'd4, 7'b0110011);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
        check(stall == 0 && illegal == 0 && xu_start == 0, "R6 other opcode ignored",
              longint'({stall, illegal, xu_start}), 0);
        @(negedge clk);
        check(start_cnt == st_before, "R6 no start", longint'(start_cnt), longint'(st_before));

        // R11: pending bit while idle
        irq_req = 4'b0001;
        @(negedge clk);
        irq_req = '0;
        check(irq_pend == 4'b0001, "R11 pend visible", longint'(irq_pend), 1);
        irq_ack = 4'b0001;
        @(negedge clk);
        irq_ack = '0;
        check(irq_pend == 4'b0000, "R11 ack clears", longint'(irq_pend), 0);

        // R10/R12: decode and interrupts during a stall
        st_before = start_cnt;
        fork
            issue(7'h02, 5'd6, 5'd7, 3'b011, 5'd12, 32'hA5A5_A5A5, 32'h5A5A_0000, 6);
            begin
                repeat (3) @(negedge clk);
                irq_req = 4'b0100;
                irq_ack = 4'b0100;
                dec_instr = mk(7'h03, 5'd1, 5'd1, 3'b000, 5'd2, 7'b0001011);
                dec_valid = 1'b1;
                check(irq_pend == '0, "R12 hidden in stall", longint'(irq_pend), 0);
                @(negedge clk);
                irq_req = '0;
                check(irq_pend == '0, "R12 hidden after pulse", longint'(irq_pend), 0);
                @(negedge clk);
                irq_ack = '0;
                dec_valid = 1'b0;
                ext_en = 1'b0;
                @(negedge clk);
                check(illegal == 1'b0, "R10 no illegal in stall", longint'(illegal), 0);
                ext_en = 1'b1;
            end
        join
        check(start_cnt == st_before + 1, "R10 one start only",
              longint'(start_cnt), longint'(st_before + 1));
        check(irq_pend == 4'b0100, "R12 shown after stall", longint'(irq_pend), 4);
        irq_ack = 4'b0100;
        @(negedge clk);
        irq_ack = '0;
        check(irq_pend == '0, "R11 ack after stall", longint'(irq_pend), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all writebacks seen", longint'(exp_q.size()), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule